// File: doc/BRIEF.md
# Framed Packet Transmit/Receive Engine

This block sits in the digital baseband of a short-range 250 kbps packet radio, between a byte-wide packet buffer and a byte-serial modem. It owns framing and nothing else. On transmit it emits a synchronisation header, a length byte, the payload and a 16-bit check sequence, one byte per modem pull. On receive it hunts for the start-of-frame code, takes the length byte, and captures the rest of the frame. It then reports whether the recomputed check matches.

The host works the engine in one of two ways, chosen by `stream_mode`. In buffered mode the payload moves through the external packet buffer, and the host sees a single strobe per frame. In streaming mode every payload byte passes through a one-byte holding register (transmit) or an output register (receive), and a per-word strobe paces the host. A transmit word that is missing when the modem needs it aborts the frame and raises an error flag.

The frame on air is: four preamble bytes of 0x00, the code 0xA7, a length byte L equal to the payload count plus 2, the payload, and then the check sequence with its low byte first. The check is a CRC-16 with polynomial x^16+x^12+x^5+1 and initial value zero. It is processed least-significant bit first, which is the reflected constant 0x8408. It covers only the payload bytes.

Top module: `frame_engine`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `tx_busy`, `irq_word`, `irq_tx_done`, `irq_rx_done`, `crc_ok` and `tx_underrun` are all 0.
- R2: A transmit frame starts with four bytes of 0x00, then 0xA7, then the length byte (payload count + 2). Each byte is held on `tx_byte` until the modem pulses `tx_take`.
- R3: In buffered mode (`stream_mode`=0), payload byte i is the byte that `buf_rdata` returns for `buf_addr`=i, sent for i = 0 upward. An empty payload (`tx_len`=0) goes straight from the length byte to the check bytes.
- R4: After the payload come two check bytes, low byte first. They hold the CRC-16 (reflected constant 0x8408, initial value 0, least-significant bit first) of the payload bytes only.
- R5: In buffered mode, `irq_tx_done` pulses for exactly one cycle, in the cycle after the edge where the second check byte is taken. `tx_busy` is low in that same cycle.
- R6: A `tx_req` with `tx_len` greater than 125 is ignored: `tx_busy` stays low.
- R7: In streaming mode (`stream_mode`=1), each payload byte comes from the last `host_wdata` loaded with `host_wvalid`. `irq_word` pulses once after the length byte is taken and once after each payload byte except the last, so a frame of N>0 bytes gives N strobes.
- R8: In streaming mode, if the modem takes a payload byte while no host word is held, `tx_underrun` goes to 1 and the frame ends at once. No check bytes are sent and no `irq_tx_done` pulses. `tx_underrun` clears on the next accepted `tx_req`.
- R9: On receive, every `rx_byte` before a 0xA7 is ignored. The byte right after the 0xA7 is taken as the length L.
- R10: A received length below 2 or above 127 abandons the frame without any strobe, and the engine goes back to hunting for 0xA7.
- R11: In buffered receive, all L bytes after the length byte (payload followed by both check bytes) are written to buffer addresses 0 to L-1 through `buf_we`/`buf_wdata`. `irq_rx_done` pulses once in the cycle after the last byte, with `rx_len`=L, and no `irq_word` occurs.
- R12: With `irq_rx_done`, `crc_ok` is 1 exactly when the received check bytes match the CRC of the received payload, and 0 otherwise.
- R13: In streaming receive, `irq_word` pulses for each payload byte (not for the check bytes) in the cycle after it arrives, with the byte on `host_rdata`. `irq_rx_done` ends the frame as in buffered mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| stream_mode | input | 1 | 0 = buffered, 1 = per-word streaming |
| tx_req | input | 1 | Start a transmit frame (accepted when idle) |
| tx_len | input | 7 | Payload byte count for the frame being requested |
| tx_take | input | 1 | Modem consumes the byte now on `tx_byte` |
| tx_byte | output | 8 | Byte offered to the modem |
| tx_busy | output | 1 | A transmit frame is in progress |
| tx_underrun | output | 1 | Sticky: streaming transmit ran out of host data |
| host_wdata | input | 8 | Streaming transmit word from the host |
| host_wvalid | input | 1 | Load `host_wdata` into the holding register |
| host_rdata | output | 8 | Streaming receive word to the host |
| rx_byte | input | 8 | Byte from the modem |
| rx_valid | input | 1 | `rx_byte` is valid this cycle |
| buf_addr | output | 7 | Packet-buffer address |
| buf_we | output | 1 | Packet-buffer write enable (receive) |
| buf_wdata | output | 8 | Packet-buffer write data |
| buf_rdata | input | 8 | Packet-buffer read data, same cycle as `buf_addr` |
| irq_word | output | 1 | Per-word strobe in streaming mode |
| irq_tx_done | output | 1 | Transmit frame completed |
| irq_rx_done | output | 1 | Receive frame completed |
| crc_ok | output | 1 | Check result of the last completed receive frame |
| rx_len | output | 7 | Length byte of the last completed receive frame |

## Verification
`tx_byte` changes in the cycle after the edge where `tx_take` is seen. Every strobe (`irq_word`, `irq_tx_done`, `irq_rx_done`) and the `crc_ok`, `rx_len`, `host_rdata` values appear in the cycle after the edge that registers the triggering take or received byte. Inputs are driven and outputs are read at the falling edge, so each check falls half a cycle after the edge that produced the value. The done strobes are checked in exactly that cycle. The per-word strobes are counted by edge-triggered counters and compared after the frame. Buffer writes are taken by a bench memory at the same rising edge as the engine's own update.

// File: rtl/frm_pkg.sv
// Shared constants and state encodings for the framed packet engine.
package frm_pkg;
    localparam int          PRE_BYTES_DEF = 4;
    localparam logic [7:0]  SFD_DEF       = 8'hA7;
    localparam int          MAX_PAY_DEF   = 125;
    localparam logic [15:0] CRC_POLY_DEF  = 16'h8408;  // x^16+x^12+x^5+1, reflected

    typedef enum logic [2:0] {
        TX_IDLE, TX_PRE, TX_SFD, TX_LEN, TX_PAY, TX_CRCL, TX_CRCH
    } tx_state_t;

    typedef enum logic [1:0] {
        RX_HUNT, RX_LEN, RX_DATA
    } rx_state_t;
endpackage

// File: rtl/frm_crc16.sv
// Byte-at-a-time CRC-16 register, least-significant bit first, no final xor.
// Assumes: clr has priority over en; crc_nxt is the value after absorbing din.
module frm_crc16 #(
    parameter logic [15:0] POLY = 16'h8408
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [15:0] crc,
    output logic [15:0] crc_nxt
);
    logic [15:0] crc_q;

    // Unrolled eight-bit update of the running remainder.
    always_comb begin
        logic [15:0] c;
        c = crc_q;
        for (int i = 0; i < 8; i++) begin
            if (c[0] ^ din[i]) c = (c >> 1) ^ POLY;
            else               c = c >> 1;
        end
        crc_nxt = c;
    end

    // Remainder register: clear on frame start, update on each absorbed byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) crc_q <= '0;
        else if (en)       crc_q <= crc_nxt;
    end

    assign crc = crc_q;

    // R4: a clear always leaves a zero remainder for the next frame
    a_r4_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (crc == 16'h0000));
endmodule

// File: rtl/frm_tx.sv
// Transmit framer: emits header, length, payload and check bytes to a modem that
// pulls one byte per tx_take pulse. Payload comes from the packet buffer
// (buffered) or from a one-byte host holding register (streaming).
// Assumes: buf_rdata is valid in the same cycle as buf_addr.
module frm_tx
    import frm_pkg::*;
#(
    parameter int          PRE_BYTES = PRE_BYTES_DEF,
    parameter logic [7:0]  SFD       = SFD_DEF,
    parameter int          MAX_PAY   = MAX_PAY_DEF,
    parameter logic [15:0] POLY      = CRC_POLY_DEF,
    parameter int          AW        = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stream_mode,
    input  logic          tx_req,
    input  logic [AW-1:0] tx_len,
    input  logic          tx_take,
    input  logic [7:0]    host_wdata,
    input  logic          host_wvalid,
    input  logic [7:0]    buf_rdata,
    output logic [AW-1:0] buf_addr,
    output logic [7:0]    tx_byte,
    output logic          tx_busy,
    output logic          irq_word,
    output logic          irq_done,
    output logic          underrun
);
    tx_state_t     state;
    logic [AW-1:0] cnt;
    logic [AW-1:0] len_r;
    logic [7:0]    hold;
    logic          hold_full;
    logic [15:0]   crc;
    logic [15:0]   crc_nxt;
    logic          accept;
    logic          starved;
    logic          pay_take;

    assign accept   = (state == TX_IDLE) && tx_req && (tx_len <= AW'(MAX_PAY));
    assign starved  = stream_mode && !hold_full;
    assign pay_take = (state == TX_PAY) && tx_take;
    assign tx_busy  = (state != TX_IDLE);
    assign buf_addr = cnt;

    // Byte offered to the modem for the current frame position.
    always_comb begin
        unique case (state)
            TX_SFD:  tx_byte = SFD;
            TX_LEN:  tx_byte = 8'(len_r) + 8'd2;
            TX_PAY:  tx_byte = stream_mode ? hold : buf_rdata;
            TX_CRCL: tx_byte = crc[7:0];
            TX_CRCH: tx_byte = crc[15:8];
            default: tx_byte = 8'h00;
        endcase
    end

    frm_crc16 #(.POLY(POLY)) u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (accept),
        .en      (pay_take && !starved),
        .din     (tx_byte),
        .crc     (crc),
        .crc_nxt (crc_nxt)
    );

    // Streaming holding register: a host load wins over consumption.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold      <= '0;
            hold_full <= 1'b0;
        end else if (host_wvalid) begin
            hold      <= host_wdata;
            hold_full <= 1'b1;
        end else if (pay_take && stream_mode) begin
            hold_full <= 1'b0;
        end
    end

    // Frame sequencer, advanced once per modem take.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= TX_IDLE;
            cnt      <= '0;
            len_r    <= '0;
            irq_word <= 1'b0;
            irq_done <= 1'b0;
            underrun <= 1'b0;
        end else begin
            irq_word <= 1'b0;
            irq_done <= 1'b0;
            unique case (state)
                TX_IDLE: if (accept) begin
                    state    <= TX_PRE;
                    cnt      <= '0;
                    len_r    <= tx_len;
                    underrun <= 1'b0;
                end
                TX_PRE: if (tx_take) begin
                    if (cnt == AW'(PRE_BYTES - 1)) begin
                        cnt   <= '0;
                        state <= TX_SFD;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                TX_SFD: if (tx_take) state <= TX_LEN;
                TX_LEN: if (tx_take) begin
                    state    <= (len_r == '0) ? TX_CRCL : TX_PAY;
                    irq_word <= stream_mode && (len_r != '0);
                end
                TX_PAY: if (tx_take) begin
                    if (starved) begin
                        underrun <= 1'b1;
                        state    <= TX_IDLE;
                    end else if (cnt == len_r - 1'b1) begin
                        state <= TX_CRCL;
                    end else begin
                        cnt      <= cnt + 1'b1;
                        irq_word <= stream_mode;
                    end
                end
                TX_CRCL: if (tx_take) state <= TX_CRCH;
                TX_CRCH: if (tx_take) begin
                    state    <= TX_IDLE;
                    irq_done <= 1'b1;
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

    // R5: completion only follows the take of the second check byte
    a_r5_done_after_check: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |-> $past(state == TX_CRCH && tx_take));
    // R6: an oversize request leaves the engine idle
    a_r6_oversize_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_busy && tx_req && (tx_len > AW'(MAX_PAY))) |=> !tx_busy);
    // R8: an underrun ends the frame with no completion strobe
    a_r8_underrun_no_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> (!tx_busy && !irq_done));
    // R2: outside the payload, the offered byte holds until the modem takes it
    a_r2_byte_held: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy && !tx_take && state != TX_PAY) |=> $stable(tx_byte));
endmodule

// File: rtl/frm_rx.sv
// Receive deframer: hunts for the start code, checks the length byte, then
// captures payload and check bytes and reports the CRC result.
// Assumes: one byte per rx_valid cycle; the transmitter is idle while receiving.
module frm_rx
    import frm_pkg::*;
#(
    parameter logic [7:0]  SFD  = SFD_DEF,
    parameter logic [15:0] POLY = CRC_POLY_DEF,
    parameter int          AW   = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stream_mode,
    input  logic [7:0]    rx_byte,
    input  logic          rx_valid,
    output logic [AW-1:0] buf_addr,
    output logic          buf_we,
    output logic [7:0]    buf_wdata,
    output logic [7:0]    host_rdata,
    output logic          irq_word,
    output logic          irq_done,
    output logic          crc_ok,
    output logic [AW-1:0] rx_len
);
    localparam int MAX_LEN = (1 << AW) - 1;

    rx_state_t     state;
    logic [AW-1:0] cnt;
    logic [AW-1:0] len_r;
    logic [15:0]   crc;
    logic [15:0]   crc_nxt;
    logic          len_ok;
    logic          data_in;
    logic          last;

    assign len_ok    = (rx_byte >= 8'd2) && (rx_byte <= 8'(MAX_LEN));
    assign data_in   = (state == RX_DATA) && rx_valid;
    assign last      = (cnt == len_r - 1'b1);
    assign buf_addr  = cnt;
    assign buf_we    = data_in && !stream_mode;
    assign buf_wdata = rx_byte;

    frm_crc16 #(.POLY(POLY)) u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     ((state == RX_LEN) && rx_valid),
        .en      (data_in),
        .din     (rx_byte),
        .crc     (crc),
        .crc_nxt (crc_nxt)
    );

    // Hunt, length check and byte capture sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= RX_HUNT;
            cnt        <= '0;
            len_r      <= '0;
            host_rdata <= '0;
            irq_word   <= 1'b0;
            irq_done   <= 1'b0;
            crc_ok     <= 1'b0;
            rx_len     <= '0;
        end else begin
            irq_word <= 1'b0;
            irq_done <= 1'b0;
            unique case (state)
                RX_HUNT: if (rx_valid && rx_byte == SFD) state <= RX_LEN;
                RX_LEN: if (rx_valid) begin
                    if (len_ok) begin
                        len_r <= rx_byte[AW-1:0];
                        cnt   <= '0;
                        state <= RX_DATA;
                    end else begin
                        state <= RX_HUNT;
                    end
                end
                RX_DATA: if (rx_valid) begin
                    if (stream_mode && (cnt < len_r - AW'(2))) begin
                        irq_word   <= 1'b1;
                        host_rdata <= rx_byte;
                    end
                    if (last) begin
                        state    <= RX_HUNT;
                        irq_done <= 1'b1;
                        crc_ok   <= (crc_nxt == 16'h0000);
                        rx_len   <= len_r;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= RX_HUNT;
            endcase
        end
    end

    // R11: frame completion always follows a received byte
    a_r11_done_on_byte: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |-> $past(rx_valid));
    // R13: receive word strobes only in streaming mode, after a received byte
    a_r13_word_stream: assert property (@(posedge clk) disable iff (!rst_n)
        irq_word |-> $past(stream_mode && rx_valid));
    // R10: capture runs only with a legal length
    a_r10_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_DATA) |-> (len_r >= AW'(2)));
    // R11: buffer writes never happen in streaming mode
    a_r11_no_buf_stream: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> !stream_mode);
endmodule

// File: rtl/frame_engine.sv
// Framed packet engine top: joins the transmit framer and the receive deframer,
// shares the packet-buffer port and merges the per-word strobes.
// Assumes half-duplex use: transmit owns the buffer address while busy.
module frame_engine
    import frm_pkg::*;
#(
    parameter int          PRE_BYTES = PRE_BYTES_DEF,
    parameter logic [7:0]  SFD       = SFD_DEF,
    parameter int          MAX_PAY   = MAX_PAY_DEF,
    parameter logic [15:0] POLY      = CRC_POLY_DEF,
    localparam int         AW        = $clog2(MAX_PAY + 3)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stream_mode,
    input  logic          tx_req,
    input  logic [AW-1:0] tx_len,
    input  logic          tx_take,
    output logic [7:0]    tx_byte,
    output logic          tx_busy,
    output logic          tx_underrun,
    input  logic [7:0]    host_wdata,
    input  logic          host_wvalid,
    output logic [7:0]    host_rdata,
    input  logic [7:0]    rx_byte,
    input  logic          rx_valid,
    output logic [AW-1:0] buf_addr,
    output logic          buf_we,
    output logic [7:0]    buf_wdata,
    input  logic [7:0]    buf_rdata,
    output logic          irq_word,
    output logic          irq_tx_done,
    output logic          irq_rx_done,
    output logic          crc_ok,
    output logic [AW-1:0] rx_len
);
    logic [AW-1:0] tx_addr;
    logic [AW-1:0] rx_addr;
    logic          tx_word;
    logic          rx_word;

    frm_tx #(
        .PRE_BYTES (PRE_BYTES),
        .SFD       (SFD),
        .MAX_PAY   (MAX_PAY),
        .POLY      (POLY),
        .AW        (AW)
    ) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .stream_mode (stream_mode),
        .tx_req      (tx_req),
        .tx_len      (tx_len),
        .tx_take     (tx_take),
        .host_wdata  (host_wdata),
        .host_wvalid (host_wvalid),
        .buf_rdata   (buf_rdata),
        .buf_addr    (tx_addr),
        .tx_byte     (tx_byte),
        .tx_busy     (tx_busy),
        .irq_word    (tx_word),
        .irq_done    (irq_tx_done),
        .underrun    (tx_underrun)
    );

    frm_rx #(
        .SFD  (SFD),
        .POLY (POLY),
        .AW   (AW)
    ) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .stream_mode (stream_mode),
        .rx_byte     (rx_byte),
        .rx_valid    (rx_valid),
        .buf_addr    (rx_addr),
        .buf_we      (buf_we),
        .buf_wdata   (buf_wdata),
        .host_rdata  (host_rdata),
        .irq_word    (rx_word),
        .irq_done    (irq_rx_done),
        .crc_ok      (crc_ok),
        .rx_len      (rx_len)
    );

    // Buffer address belongs to transmit while a frame is going out.
    assign buf_addr = tx_busy ? tx_addr : rx_addr;
    assign irq_word = tx_word | rx_word;

    // R5: the two completion strobes never fire together in half-duplex use
    a_r5_done_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_tx_done && irq_rx_done && !$past(tx_busy && rx_valid)));
endmodule

// File: tb/test_frame_engine.sv
module test_frame_engine;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stream_mode = 1'b0;
    logic       tx_req = 1'b0;
    logic [6:0] tx_len = '0;
    logic       tx_take = 1'b0;
    logic [7:0] tx_byte;
    logic       tx_busy;
    logic       tx_underrun;
    logic [7:0] host_wdata = '0;
    logic       host_wvalid = 1'b0;
    logic [7:0] host_rdata;
    logic [7:0] rx_byte = '0;
    logic       rx_valid = 1'b0;
    logic [6:0] buf_addr;
    logic       buf_we;
    logic [7:0] buf_wdata;
    logic [7:0] buf_rdata;
    logic       irq_word;
    logic       irq_tx_done;
    logic       irq_rx_done;
    logic       crc_ok;
    logic [6:0] rx_len;

    int n_tests = 0;
    int n_fail  = 0;

    logic [7:0] txmem [0:127];
    logic [7:0] rxmem [0:127];
    logic [7:0] wcap  [0:255];
    logic [7:0] fr    [0:139];
    logic [7:0] rec   [0:139];
    logic [7:0] pay   [0:127];
    int word_cnt = 0;
    int txd_cnt  = 0;
    int rxd_cnt  = 0;

    always #5 clk = ~clk;

    frame_engine i_frame_engine (
        .clk(clk), .rst_n(rst_n), .stream_mode(stream_mode),
        .tx_req(tx_req), .tx_len(tx_len), .tx_take(tx_take),
        .tx_byte(tx_byte), .tx_busy(tx_busy), .tx_underrun(tx_underrun),
        .host_wdata(host_wdata), .host_wvalid(host_wvalid), .host_rdata(host_rdata),
        .rx_byte(rx_byte), .rx_valid(rx_valid),
        .buf_addr(buf_addr), .buf_we(buf_we), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
        .irq_word(irq_word), .irq_tx_done(irq_tx_done), .irq_rx_done(irq_rx_done),
        .crc_ok(crc_ok), .rx_len(rx_len)
    );

    assign buf_rdata = txmem[buf_addr];

    always @(posedge clk) begin
        if (buf_we) rxmem[buf_addr] <= buf_wdata;
        if (irq_word) begin
            wcap[word_cnt[7:0]] <= host_rdata;
            word_cnt <= word_cnt + 1;
        end
        if (irq_tx_done) txd_cnt <= txd_cnt + 1;
        if (irq_rx_done) rxd_cnt <= rxd_cnt + 1;
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Reference CRC: reflected CCITT polynomial, zero start, LSB first.
    function automatic logic [15:0] crc_ref(input int len, input int base);
        logic [15:0] r = 16'h0000;
        for (int k = 0; k < len; k++) begin
            logic [7:0] b = pay[base + k];
            for (int j = 0; j < 8; j++) begin
                logic fb = r[0] ^ b[j];
                r = {1'b0, r[15:1]};
                if (fb) r = r ^ 16'h8408;
            end
        end
        return r;
    endfunction

    // Fills fr[] with the full on-air frame for pay[0..len-1]; returns its size.
    function automatic int build_frame(input int len);
        logic [15:0] c = crc_ref(len, 0);
        for (int k = 0; k < 4; k++) fr[k] = 8'h00;
        fr[4] = 8'hA7;
        fr[5] = 8'(len + 2);
        for (int k = 0; k < len; k++) fr[6 + k] = pay[k];
        fr[6 + len] = c[7:0];
        fr[7 + len] = c[15:8];
        return len + 8;
    endfunction

    task automatic start_tx(input int len);
        tx_len = 7'(len);
        tx_req = 1'b1;
        @(negedge clk);
        tx_req = 1'b0;
    endtask

    task automatic t_reset();
        chk(!tx_busy && !irq_word && !irq_tx_done && !irq_rx_done && !crc_ok && !tx_underrun,
            "R1 reset state", {tx_busy, irq_word, irq_tx_done, irq_rx_done, crc_ok, tx_underrun}, 0);
    endtask

    task automatic t_tx_buf(input int len, input int seed);
        int n = 0;
        int bad = 0;
        int sz;
        int d0 = txd_cnt;
        logic done_seen;
        stream_mode = 1'b0;
        for (int k = 0; k < 128; k++) begin
            txmem[k] = 8'(k * 29 + seed);
            pay[k]   = txmem[k];
        end
        sz = build_frame(len);
        start_tx(len);
        while (tx_busy && n < 140) begin
            rec[n] = tx_byte;
            tx_take = 1'b1;
            @(negedge clk);
            tx_take = 1'b0;
            n++;
        end
        done_seen = irq_tx_done;
        for (int k = 0; k < sz; k++) if (rec[k] !== fr[k]) bad++;
        chk(n == sz, "R2 frame byte count", n, sz);
        chk(bad == 0 && rec[4] == 8'hA7 && rec[5] == 8'(len + 2),
            "R2/R3 header and payload bytes", bad, 0);
        chk({rec[sz-1], rec[sz-2]} == crc_ref(len, 0), "R4 check bytes low first",
            int'({rec[sz-1], rec[sz-2]}), int'(crc_ref(len, 0)));
        chk(done_seen && !tx_busy, "R5 done strobe in cycle after last take", done_seen, 1);
        @(negedge clk);
        chk(txd_cnt - d0 == 1 && !irq_tx_done, "R5 single done strobe", txd_cnt - d0, 1);
    endtask

    task automatic t_tx_oversize();
        stream_mode = 1'b0;
        start_tx(126);
        chk(!tx_busy, "R6 oversize request ignored", tx_busy, 0);
        @(negedge clk);
        chk(!tx_busy, "R6 still idle", tx_busy, 0);
    endtask

    // Streaming transmit; the host answers each word strobe until 'supply' words.
    task automatic t_tx_stream(input int len, input int supply);
        int n = 0;
        int sent = 0;
        int bad = 0;
        int sz;
        int w0 = word_cnt;
        int d0 = txd_cnt;
        logic modem_done = 1'b0;
        stream_mode = 1'b1;
        for (int k = 0; k < len; k++) pay[k] = 8'(8'hC3 ^ (k * 17));
        sz = build_frame(len);
        start_tx(len);
        fork
            begin
                while (tx_busy && n < 140) begin
                    rec[n] = tx_byte;
                    tx_take = 1'b1;
                    @(negedge clk);
                    tx_take = 1'b0;
                    n++;
                    repeat (3) @(negedge clk);
                end
                modem_done = 1'b1;
            end
            begin
                while (!modem_done) begin
                    @(negedge clk);
                    host_wvalid = 1'b0;
                    if (irq_word && sent < supply) begin
                        host_wdata  = pay[sent];
                        host_wvalid = 1'b1;
                        sent++;
                    end
                end
                host_wvalid = 1'b0;
            end
        join
        if (supply >= len) begin
            for (int k = 0; k < sz; k++) if (rec[k] !== fr[k]) bad++;
            chk(n == sz && bad == 0, "R7 streamed frame bytes", bad, 0);
            chk(word_cnt - w0 == len, "R7 word strobes per frame", word_cnt - w0, len);
            chk(txd_cnt - d0 == 1 && !tx_underrun, "R7 streamed frame completes",
                txd_cnt - d0, 1);
        end else begin
            chk(tx_underrun, "R8 underrun flag set", tx_underrun, 1);
            chk(n == 7 + supply, "R8 frame cut before check bytes", n, 7 + supply);
            chk(txd_cnt - d0 == 0, "R8 no done strobe on underrun", txd_cnt - d0, 0);
        end
        stream_mode = 1'b0;
    endtask

    task automatic send_rx(input logic [7:0] b);
        rx_byte  = b;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    // Receives a frame for pay[0..len-1]; corrupt flips one check bit.
    task automatic t_rx(input int len, input logic corrupt, input logic strm, input logic junk);
        int sz;
        int bad = 0;
        int w0 = word_cnt;
        int d0 = rxd_cnt;
        logic done_seen;
        logic ok_seen;
        logic [6:0] l_seen;
        stream_mode = strm;
        for (int k = 0; k < len; k++) pay[k] = 8'(k * 53 + 8'h1D);
        if (len > 1) pay[1] = 8'hA7;
        sz = build_frame(len);
        if (corrupt) fr[sz - 1] = fr[sz - 1] ^ 8'h10;
        if (junk) begin
            send_rx(8'h55);
            send_rx(8'hA6);
            send_rx(8'hFF);
        end
        for (int k = 0; k < sz; k++) send_rx(fr[k]);
        done_seen = irq_rx_done;
        ok_seen   = crc_ok;
        l_seen    = rx_len;
        @(negedge clk);
        chk(done_seen && rxd_cnt - d0 == 1, "R11 single done strobe after last byte",
            rxd_cnt - d0, 1);
        chk(l_seen == 7'(len + 2), "R9/R11 captured length", l_seen, len + 2);
        chk(ok_seen == !corrupt, "R12 check result", ok_seen, !corrupt);
        if (strm) begin
            for (int k = 0; k < len; k++) if (wcap[8'(w0 + k)] !== pay[k]) bad++;
            chk(word_cnt - w0 == len, "R13 receive word strobes", word_cnt - w0, len);
            chk(bad == 0, "R13 streamed receive words", bad, 0);
        end else begin
            for (int k = 0; k < len + 2; k++) if (rxmem[k] !== fr[6 + k]) bad++;
            chk(bad == 0, "R11 buffer holds payload and check", bad, 0);
            chk(word_cnt == w0, "R11 no word strobe in buffered", word_cnt - w0, 0);
        end
        stream_mode = 1'b0;
    endtask

    task automatic t_rx_abort();
        int d0 = rxd_cnt;
        send_rx(8'hA7);
        send_rx(8'h01);
        send_rx(8'hA7);
        send_rx(8'hC8);
        send_rx(8'h33);
        @(negedge clk);
        chk(rxd_cnt == d0, "R10 illegal lengths give no strobe", rxd_cnt - d0, 0);
        t_rx(2, 1'b0, 1'b0, 1'b0);
        chk(rxd_cnt - d0 == 1, "R10 hunt resumes after abort", rxd_cnt - d0, 1);
    endtask

    initial begin
        for (int k = 0; k < 128; k++) begin
            txmem[k] = '0;
            rxmem[k] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_tx_buf(3, 7);
        t_tx_buf(0, 1);
        t_tx_buf(125, 90);
        t_tx_oversize();
        t_tx_stream(4, 4);
        t_tx_stream(5, 2);
        t_tx_buf(2, 4);
        chk(!tx_underrun, "R8 underrun cleared by next request", tx_underrun, 0);
        t_rx(5, 1'b0, 1'b0, 1'b1);
        t_rx(7, 1'b1, 1'b0, 1'b0);
        t_rx_abort();
        t_rx(6, 1'b0, 1'b1, 1'b1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule